// File: doc/BRIEF.md
# Boot ROM and Shadow Window Address Decoder

This block sits between a processor's physical address output and the memory system. Each cycle it may take one 32-bit request (read or write) and route it to the boot ROM, to RAM, or to nowhere. The boot ROM is mapped at the top of the 4 GiB space. Its size is a power of two that firmware picks through a configuration register, and the ROM always covers the reset fetch address. RAM covers the bottom of the space, up to a size set by a parameter.

A small legacy window sits just below the 1 MiB boundary and ends at 0x000FFFFF. Once firmware has copied boot code into RAM there, it can turn the window into shadow RAM. Reads from the window still reach RAM. Writes either pass through or are dropped silently, which makes the copy read-only. A dropped write, or an access that hits nothing, still completes one cycle later, so the requester never waits.

Routing is registered. The target strobes, the forwarded address and data, the completion pulse and the unmapped flag all appear one cycle after the request. The read data the core sees is chosen from the selected target's data input in that cycle.

Top module: `boot_addr_decoder`

## Requirements
- R1: After reset, all target strobes, `rsp_done` and `rsp_unmapped` are low. The ROM size code is ROM_CODE_RST (default 5, meaning 2 MiB), and the legacy window is disabled.
- R2: The ROM size is 2^(16+k) bytes, where k is the configured code, and any k above 8 is treated as 8. An address at or above 2^32 − size asserts `rom_sel` one cycle after the request, and this takes priority over RAM.
- R3: A request to 0xFFFFFFF0 always selects the ROM, whatever the configuration.
- R4: A non-ROM address below 2^RAM_LOG2 (default 2^31) asserts `ram_sel` one cycle later. `mem_addr`, `mem_write` and `mem_wdata` carry the request unchanged.
- R5: While the window is disabled, writes into the window region reach RAM.
- R6: With the window enabled and write-ignore set, a write to the window (0x00100000 − 2^LEG_LOG2 up to 0x000FFFFF, default 0xE0000 to 0xFFFFF) asserts neither strobe but still gives `rsp_done`. Reads from the window still select RAM, and writes just below the window still reach RAM.
- R7: With the window enabled and write-ignore clear, writes to the window reach RAM.
- R8: A request that hits neither ROM nor RAM raises `rsp_unmapped` for one cycle with no strobe, and `rsp_rdata` is all ones.
- R9: Every request gives exactly one `rsp_done` pulse in the next cycle, with no stall, and idle cycles give none.
- R10: At most one of `rom_sel` and `ram_sel` is high in any cycle.
- R11: A configuration write with `cfg_sel`=0 loads the ROM code from `cfg_wdata[3:0]`. With `cfg_sel`=1, bit 0 is the window enable and bit 1 is write-ignore. The new values apply from the next cycle's request onward, and a request in the same cycle uses the old values.
- R12: For a read, `rsp_rdata` equals `rom_rdata` when `rom_sel` is high and `ram_rdata` when `ram_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical address |
| req_wdata | input | 32 | Write data |
| rom_sel | output | 1 | Request strobe to the boot ROM |
| ram_sel | output | 1 | Request strobe to RAM |
| mem_write | output | 1 | Forwarded write flag |
| mem_addr | output | 32 | Forwarded address |
| mem_wdata | output | 32 | Forwarded write data |
| rom_rdata | input | 32 | Read data from the ROM |
| ram_rdata | input | 32 | Read data from RAM |
| rsp_done | output | 1 | Request complete |
| rsp_unmapped | output | 1 | Request hit no region |
| rsp_rdata | output | 32 | Read data returned to the core |

## Verification
The embedded properties check on every cycle that the two targets are never selected together, that the reset fetch address always lands on the ROM, that each request completes one cycle later, that a write dropped by the window asserts no strobe, and that an unmapped access returns all ones. Other behaviour only shows up in the bench's scenarios, because it depends on a sequence of configuration changes. This covers moving the ROM boundary when the size code changes, clamping oversized codes, the exact edges of the window and of RAM, and a request in the same cycle as a configuration write using the old settings. The bench's reference model predicts every output on every clock across these sequences.

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder #(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int RAM_LOG2     = 31,
  parameter int LEG_LOG2     = 17,
  parameter int ROM_MIN_LOG2 = 16,
  parameter int ROM_MAX_CODE = 8,
  parameter int ROM_CODE_RST = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rom_sel,
  output logic          ram_sel,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          rsp_done,
  output logic          rsp_unmapped,
  output logic [DW-1:0] rsp_rdata
);

  localparam logic [AW:0]   RAM_TOP  = (AW+1)'(1) << RAM_LOG2;
  localparam logic [AW-1:0] LEG_END  = AW'(32'h0010_0000);
  localparam logic [AW-1:0] LEG_BASE = LEG_END - (AW'(1) << LEG_LOG2);
  localparam logic [AW-1:0] RST_VEC  = AW'(32'hFFFF_FFF0);

  logic [3:0]    rom_code;
  logic          win_en;
  logic          win_ign;
  logic [3:0]    code_eff;
  logic [5:0]    rom_lg;
  logic [AW-1:0] rom_mask;
  logic          hit_rom, hit_ram, hit_win, drop_wr;

  assign code_eff = (rom_code > 4'(ROM_MAX_CODE)) ? 4'(ROM_MAX_CODE) : rom_code;
  assign rom_lg   = 6'(ROM_MIN_LOG2) + {2'b00, code_eff};
  assign rom_mask = {AW{1'b1}} << rom_lg;
  assign hit_rom  = (req_addr & rom_mask) == rom_mask;
  assign hit_ram  = {1'b0, req_addr} < RAM_TOP;
  assign hit_win  = win_en && req_addr >= LEG_BASE && req_addr < LEG_END;
  assign drop_wr  = hit_win && win_ign && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_code <= 4'(ROM_CODE_RST);
      win_en   <= 1'b0;
      win_ign  <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel == 2'd0) rom_code <= cfg_wdata[3:0];
      if (cfg_sel == 2'd1) begin
        win_en  <= cfg_wdata[0];
        win_ign <= cfg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_sel      <= 1'b0;
      ram_sel      <= 1'b0;
      rsp_done     <= 1'b0;
      rsp_unmapped <= 1'b0;
      mem_write    <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
    end else begin
      rom_sel      <= req_valid && hit_rom;
      ram_sel      <= req_valid && !hit_rom && hit_ram && !drop_wr;
      rsp_unmapped <= req_valid && !hit_rom && !hit_ram;
      rsp_done     <= req_valid;
      if (req_valid) begin
        mem_write <= req_write;
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
      end
    end
  end

  assign rsp_rdata = rom_sel ? rom_rdata : ram_sel ? ram_rdata : {DW{1'b1}};

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel)); // R10

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == RST_VEC) |=> rom_sel); // R3

  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done && !rom_sel && !ram_sel); // R9

  AST_WIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && win_en && win_ign &&
     req_addr >= LEG_BASE && req_addr < LEG_END) |=> (rsp_done && !ram_sel && !rom_sel)); // R6

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unmapped |-> (rsp_rdata == {DW{1'b1}} && !rom_sel && !ram_sel)); // R8

endmodule

// File: tb/boot_addr_decoder_tb.sv
module boot_addr_decoder_tb;
  localparam int RAM_LOG2 = 31;
  localparam logic [31:0] ROMD = 32'hA5A5_0F0F;
  localparam logic [31:0] RAMD = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rom_sel, ram_sel, mem_write, rsp_done, rsp_unmapped;
  logic [31:0] mem_addr, mem_wdata, rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int m_code = 5;
  bit m_en = 0, m_ign = 0;

  always #2 clk = ~clk;

  boot_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rom_rdata(ROMD), .ram_rdata(RAMD), .rsp_done(rsp_done),
    .rsp_unmapped(rsp_unmapped), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, logic [31:0] a,
                      bit cw = 0, logic [1:0] cs = 0, logic [7:0] cd = 0);
    bit e_rom, e_ram, e_unm;
    longint lg, base;
    req_valid = v; req_write = w; req_addr = a; req_wdata = a ^ 32'h5A5A_5A5A;
    cfg_wr = cw; cfg_sel = cs; cfg_wdata = cd;
    @(posedge clk);
    lg = 16 + ((m_code > 8) ? 8 : m_code);
    base = (64'd1 << 32) - (64'd1 << lg);
    e_rom = 0; e_ram = 0; e_unm = 0;
    if (v) begin
      if (longint'(a) >= base) e_rom = 1;
      else if (longint'(a) < (64'd1 << RAM_LOG2)) begin
        if (!(w && m_en && m_ign && a >= 32'h000E_0000 && a <= 32'h000F_FFFF)) e_ram = 1;
      end else e_unm = 1;
    end
    if (cw && cs == 2'd0) m_code = int'(cd[3:0]);
    if (cw && cs == 2'd1) begin m_en = cd[0]; m_ign = cd[1]; end
    @(negedge clk);
    req_valid = 0; cfg_wr = 0;
    chk(tag, "rom_sel", 32'(rom_sel), 32'(e_rom));
    chk(tag, "ram_sel", 32'(ram_sel), 32'(e_ram));
    chk(tag, "rsp_done", 32'(rsp_done), 32'(v));
    chk(tag, "rsp_unmapped", 32'(rsp_unmapped), 32'(e_unm));
    if (v) begin
      chk(tag, "mem_addr", mem_addr, a);
      chk(tag, "mem_write", 32'(mem_write), 32'(w));
      if (w) chk(tag, "mem_wdata", mem_wdata, a ^ 32'h5A5A_5A5A);
      else chk(tag, "rsp_rdata", rsp_rdata, e_rom ? ROMD : e_ram ? RAMD : 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rom_sel", 32'(rom_sel), 0);
    chk("R1", "ram_sel", 32'(ram_sel), 0);
    chk("R1", "rsp_done", 32'(rsp_done), 0);
    chk("R1", "rsp_unmapped", 32'(rsp_unmapped), 0);
    rst_n = 1;
    step("R9", 0, 0, 0);
    step("R3", 1, 0, 32'hFFFF_FFF0);
    step("R3", 1, 1, 32'hFFFF_FFF0);
    step("R2", 1, 0, 32'hFFE0_0000);
    step("R8", 1, 0, 32'hFFDF_FFFC);
    step("R4", 1, 0, 32'h0000_1000);
    step("R4", 1, 1, 32'h7FFF_FFFC);
    step("R8", 1, 0, 32'h8000_0000);
    step("R12", 1, 0, 32'h0001_0000);
    step("R5", 1, 1, 32'h000F_0000);
    // R11 config write with no request, then window enabled with write-ignore
    step("R11", 0, 0, 0, 1, 2'd1, 8'h03);
    step("R6", 1, 1, 32'h000E_0000);
    step("R6", 1, 1, 32'h000F_FFFC);
    step("R6", 1, 0, 32'h000F_FFFC);
    step("R6", 1, 1, 32'h000D_FFFC);
    step("R6", 1, 1, 32'h0010_0000);
    step("R7", 0, 0, 0, 1, 2'd1, 8'h01);
    step("R7", 1, 1, 32'h000F_0000);
    // R11 same-cycle config write: request uses old 2 MiB ROM
    step("R11", 1, 0, 32'hFFF0_0000, 1, 2'd0, 8'h00);
    step("R2", 1, 0, 32'hFFFF_0000);
    step("R2", 1, 0, 32'hFFFE_FFFC);
    step("R3", 1, 0, 32'hFFFF_FFF0);
    step("R2", 0, 0, 0, 1, 2'd0, 8'h0F);
    step("R2", 1, 0, 32'hFF00_0000);
    step("R2", 1, 1, 32'hFEFF_FFFC);
    step("R11", 1, 1, 32'h000E_0000, 1, 2'd1, 8'h03);
    step("R6", 1, 1, 32'h000E_0000);
    step("R9", 1, 0, 32'h0000_0004);
    step("R10", 1, 0, 32'hFFFF_FFFC);
    step("R9", 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule